// File: doc/BRIEF.md
# DRAM Page Mode Controller

This block drives up to eight DRAM banks through per-bank row strobes, four byte-lane column strobes, a multiplexed address bus and a write strobe. It splits each request address into a bank, a row and a column, using a bank size and a port width set by configuration inputs. It keeps a record of the open row in every bank that has page mode enabled.

Each accepted request is classed against that record. A page hit strobes only the column. A page miss closes the row for two clocks and then opens the new one. An access to a bank with no open row runs a normal cycle. Line fills run four column beats with a fixed 3-2-2-2 clock cadence. A separate refresh scheduler asks for the memory through a request/grant pair. While the grant is held, every row is closed, and each bank's next access opens its row again.

Top module: `dram_page_ctrl`

## Requirements
- R1: The bank is the request address bits [26:24], and bank b drives only ras_n[b]. Rows left open in other banks keep their ras_n low while another bank is being accessed.
- R2: The bank size code c (0..7) for bank b is read from cfg_bank_size[3b+2:3b]. It gives a bank span of 2^(17+c) bytes, and address bits at or above that span are ignored. The word address is the in-bank offset shifted right by 2 on a 32-bit port (cfg_port32=1) or by 1 on a 16-bit port. With w = 17+c-shift word bits, the column is the low ceil(w/2) word bits and the row is the rest.
- R3: A normal access drives the row on dram_addr with ras_n high for one clock. Then ras_n falls with the row held for one clock. Then the column is driven with all cas_n high for one clock. Then cas_n is low for two clocks, and beat_ack pulses in the second of them.
- R4: A page hit, meaning the same bank and same row as the open row, keeps ras_n low. It starts directly with the column clock in the first cycle after acceptance.
- R5: A page miss, meaning an open row that differs, holds that bank's ras_n high for two clocks. It then runs the normal row sequence.
- R6: A bank whose cfg_page_en bit is 0 has ras_n high again in the first idle cycle after its access, and its next access is a normal one. A page-enabled bank keeps ras_n low after the access.
- R7: While a column strobe is active on a 32-bit port, cas_n[i] = ~req_be[i]. On a 16-bit port, cas_n[1:0] = ~req_be[1:0], and cas_n[3:2] stay high whatever req_be[3:2] holds.
- R8: A burst runs four beats. The low two column bits of beat k are the start column's low bits plus k, modulo 4, and the upper bits are held. Each beat starts with one column clock, the first beat holds cas_n low for two clocks and each later beat for one, so beats last 3, 2, 2, 2 clocks.
- R9: In the idle state, ref_req wins over req_valid. ref_gnt stays high while ref_req is held. During the grant, all ras_n and cas_n are high and req_ready is low. After the grant, every bank's next access is normal.
- R10: we_n is low through the column and strobe clocks of write accesses, and high otherwise.
- R11: After reset, all ras_n and cas_n are high, we_n is high, beat_ack and ref_gnt are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this clock when high with req_valid |
| req_addr | input | 27 | Byte address; [26:24] select the bank |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | Four-beat line fill |
| req_be | input | 4 | Byte-lane enables |
| cfg_port32 | input | 1 | 1 for 32-bit DRAM port, 0 for 16-bit |
| cfg_page_en | input | 8 | Page mode enable per bank |
| cfg_bank_size | input | 24 | Three-bit size code per bank |
| ref_req | input | 1 | Refresh scheduler asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh scheduler |
| ras_n | output | 8 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per byte lane, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| we_n | output | 1 | Write strobe, active low |
| beat_ack | output | 1 | Data beat completes this clock |

## Verification
The address split is swept over all eight bank sizes on both port widths, with page mode off, so that every access is a normal one. Each size is tried with complementary offsets and an alias bit above the bank span, which shows whether the row/column boundary and the masking are right. With page mode on, a fixed sequence of same-row, changed-row, other-bank and disabled-bank accesses sets apart the hit, miss and normal timings and shows open rows surviving in idle banks. Bursts that start mid-line check the column wrap and the 3-2-2-2 cadence. A refresh requested together with an access shows the priority and the closing of every page.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    // Sequencer states shared by the controller modules.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_RASL,
        ST_COL,
        ST_CASL,
        ST_REF
    } seq_state_e;
endpackage

// File: rtl/dpc_addr_map.sv
// Splits a byte address into bank, row and column.
// Assumes: bank spans are powers of two from 2^BASE_LOG bytes up, banks sit
// at a fixed stride of 2^OFF_W bytes, and the row fits in MA_W bits.
module dpc_addr_map #(
    parameter int ADDR_W    = 27,
    parameter int NUM_BANKS = 8,
    parameter int MA_W      = 12,
    parameter int SIZE_W    = 3,
    parameter int BASE_LOG  = 17,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int OFF_W    = ADDR_W - BANK_W
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        port32,
    input  logic [NUM_BANKS*SIZE_W-1:0] size_cfg,
    output logic [BANK_W-1:0]           bank,
    output logic [MA_W-1:0]             row,
    output logic [MA_W-1:0]             col
);
    logic [SIZE_W-1:0] code;
    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  word;
    int unsigned       span;
    int unsigned       shift;
    int unsigned       cbits;

    // Decode bank, mask to bank span, scale to words, split at mid-point.
    always_comb begin
        bank   = addr[ADDR_W-1 -: BANK_W];
        code   = size_cfg[bank*SIZE_W +: SIZE_W];
        span   = BASE_LOG + 32'(code);
        shift  = port32 ? 32'd2 : 32'd1;
        cbits  = (span - shift + 32'd1) / 32'd2;
        offset = addr[OFF_W-1:0] & OFF_W'((64'd1 << span) - 64'd1);
        word   = offset >> shift;
        col    = MA_W'(word & OFF_W'((64'd1 << cbits) - 64'd1));
        row    = MA_W'(word >> cbits);
    end
endmodule

// File: rtl/dpc_page_table.sv
// Holds the open row and an open flag for every bank.
// Assumes: clear has priority over invalidate, which has priority over write.
module dpc_page_table #(
    parameter int NUM_BANKS = 8,
    parameter int MA_W      = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_all,
    input  logic                 inval,
    input  logic [BANK_W-1:0]    inval_idx,
    input  logic                 wr_en,
    input  logic                 wr_open,
    input  logic [BANK_W-1:0]    wr_idx,
    input  logic [MA_W-1:0]      wr_row,
    input  logic [BANK_W-1:0]    look_idx,
    input  logic [MA_W-1:0]      look_row,
    output logic [NUM_BANKS-1:0] open_vec,
    output logic                 look_open,
    output logic                 look_match
);
    logic [MA_W-1:0] rows [NUM_BANKS];

    // Update open flags and stored rows.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!rst_n || clear_all) begin
                open_vec[b] <= 1'b0;
                rows[b]     <= '0;
            end else if (inval && inval_idx == BANK_W'(b)) begin
                open_vec[b] <= 1'b0;
            end else if (wr_en && wr_idx == BANK_W'(b)) begin
                open_vec[b] <= wr_open;
                rows[b]     <= wr_row;
            end
        end
    end

    // Look up the bank of the incoming request.
    always_comb begin
        look_open  = open_vec[look_idx];
        look_match = rows[look_idx] == look_row;
    end
endmodule

// File: rtl/dpc_seq.sv
// Access sequencer: classes each request, then steps through precharge,
// row, column and strobe clocks, and hands the memory to refresh on request.
// Assumes: request fields are stable only in the accepting clock (latched here).
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int MA_W        = 12,
    parameter int LANES       = 4,
    parameter int PRE_CLKS    = 2,
    parameter int BURST_BEATS = 4,
    parameter int FIRST_CAS   = 2,
    parameter int LATER_CAS   = 1,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int BEAT_W     = $clog2(BURST_BEATS),
    localparam int PC_W       = $clog2(PRE_CLKS + 1),
    localparam int CC_W       = $clog2(FIRST_CAS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [LANES-1:0]  req_be,
    input  logic              ref_req,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [MA_W-1:0]   in_row,
    input  logic [MA_W-1:0]   in_col,
    input  logic              look_open,
    input  logic              look_match,
    output logic              req_ready,
    output logic              ref_gnt,
    output logic              tbl_clear,
    output logic              tbl_inval,
    output logic              tbl_wr,
    output logic              drv_bank,
    output logic              cas_act,
    output logic              we_low,
    output logic              beat_ack,
    output logic [BANK_W-1:0] q_bank,
    output logic [MA_W-1:0]   q_row,
    output logic [MA_W-1:0]   out_addr,
    output logic [LANES-1:0]  q_be
);
    seq_state_e      state;
    logic [PC_W-1:0] pre_cnt;
    logic [CC_W-1:0] cas_cnt;
    logic [BEAT_W-1:0] beat;
    logic [MA_W-1:0] q_col;
    logic            q_wr;
    logic            q_burst;
    logic            accept;
    logic            last_clk;
    logic [MA_W-1:0] col_beat;

    // Handshake, table control and beat bookkeeping.
    always_comb begin
        accept    = state == ST_IDLE && !ref_req && req_valid;
        req_ready = state == ST_IDLE && !ref_req;
        ref_gnt   = state == ST_REF;
        tbl_clear = state == ST_IDLE && ref_req;
        tbl_inval = accept && look_open && !look_match;
        tbl_wr    = state == ST_ROW;
        drv_bank  = state == ST_RASL || state == ST_COL || state == ST_CASL;
        cas_act   = state == ST_CASL;
        we_low    = q_wr && (state == ST_COL || state == ST_CASL);
        last_clk  = cas_cnt == CC_W'((beat == '0) ? FIRST_CAS - 1 : LATER_CAS - 1);
        beat_ack  = cas_act && last_clk;
        col_beat  = {q_col[MA_W-1:BEAT_W], q_col[BEAT_W-1:0] + beat};
        out_addr  = (state == ST_ROW || state == ST_RASL) ? q_row :
                    (state == ST_COL || state == ST_CASL) ? col_beat : '0;
    end

    // State machine and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            cas_cnt <= '0;
            beat    <= '0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_be    <= '0;
            q_wr    <= 1'b0;
            q_burst <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_req) begin
                        state <= ST_REF;
                    end else if (req_valid) begin
                        q_bank  <= in_bank;
                        q_row   <= in_row;
                        q_col   <= in_col;
                        q_be    <= req_be;
                        q_wr    <= req_write;
                        q_burst <= req_burst;
                        beat    <= '0;
                        pre_cnt <= '0;
                        if (look_open && look_match) state <= ST_COL;
                        else if (look_open)          state <= ST_PRE;
                        else                         state <= ST_ROW;
                    end
                end
                ST_PRE: begin
                    if (pre_cnt == PC_W'(PRE_CLKS - 1)) state <= ST_ROW;
                    else pre_cnt <= pre_cnt + 1'b1;
                end
                ST_ROW:  state <= ST_RASL;
                ST_RASL: state <= ST_COL;
                ST_COL: begin
                    cas_cnt <= '0;
                    state   <= ST_CASL;
                end
                ST_CASL: begin
                    if (!last_clk) begin
                        cas_cnt <= cas_cnt + 1'b1;
                    end else if (q_burst && beat != BEAT_W'(BURST_BEATS - 1)) begin
                        beat  <= beat + 1'b1;
                        state <= ST_COL;
                    end else begin
                        beat  <= '0;
                        state <= ST_IDLE;
                    end
                end
                ST_REF:  if (!ref_req) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a miss spends exactly the precharge clocks before the row clock.
    a_r5_pre_to_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE && pre_cnt == PC_W'(PRE_CLKS - 1)) |=> state == ST_ROW);

    // R4: a hit never passes through the row clocks.
    a_r4_hit_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && look_open && look_match) |=> state == ST_COL);
endmodule

// File: rtl/dram_page_ctrl.sv
// Top level: address split, open-row table and sequencer, plus pin drive
// for row strobes, byte-lane column strobes, address and write strobe.
// Assumes: configuration inputs are stable while an access is in flight.
module dram_page_ctrl #(
    parameter int ADDR_W    = 27,
    parameter int NUM_BANKS = 8,
    parameter int MA_W      = 12,
    parameter int LANES     = 4,
    parameter int SIZE_W    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int HALF     = LANES / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic                        req_burst,
    input  logic [LANES-1:0]            req_be,
    input  logic                        cfg_port32,
    input  logic [NUM_BANKS-1:0]        cfg_page_en,
    input  logic [NUM_BANKS*SIZE_W-1:0] cfg_bank_size,
    input  logic                        ref_req,
    output logic                        ref_gnt,
    output logic [NUM_BANKS-1:0]        ras_n,
    output logic [LANES-1:0]            cas_n,
    output logic [MA_W-1:0]             dram_addr,
    output logic                        we_n,
    output logic                        beat_ack
);
    logic [BANK_W-1:0]    in_bank;
    logic [MA_W-1:0]      in_row;
    logic [MA_W-1:0]      in_col;
    logic [NUM_BANKS-1:0] open_vec;
    logic                 look_open;
    logic                 look_match;
    logic                 tbl_clear;
    logic                 tbl_inval;
    logic                 tbl_wr;
    logic                 drv_bank;
    logic                 cas_act;
    logic                 we_low;
    logic [BANK_W-1:0]    q_bank;
    logic [MA_W-1:0]      q_row;
    logic [LANES-1:0]     q_be;
    logic [LANES-1:0]     lane_en;

    dpc_addr_map #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MA_W(MA_W), .SIZE_W(SIZE_W)
    ) u_map (
        .addr(req_addr), .port32(cfg_port32), .size_cfg(cfg_bank_size),
        .bank(in_bank), .row(in_row), .col(in_col)
    );

    dpc_page_table #(.NUM_BANKS(NUM_BANKS), .MA_W(MA_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clear_all(tbl_clear),
        .inval(tbl_inval), .inval_idx(in_bank),
        .wr_en(tbl_wr), .wr_open(cfg_page_en[q_bank]), .wr_idx(q_bank), .wr_row(q_row),
        .look_idx(in_bank), .look_row(in_row),
        .open_vec(open_vec), .look_open(look_open), .look_match(look_match)
    );

    dpc_seq #(.NUM_BANKS(NUM_BANKS), .MA_W(MA_W), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_be(req_be), .ref_req(ref_req),
        .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
        .look_open(look_open), .look_match(look_match),
        .req_ready(req_ready), .ref_gnt(ref_gnt), .tbl_clear(tbl_clear),
        .tbl_inval(tbl_inval), .tbl_wr(tbl_wr), .drv_bank(drv_bank),
        .cas_act(cas_act), .we_low(we_low), .beat_ack(beat_ack),
        .q_bank(q_bank), .q_row(q_row), .out_addr(dram_addr), .q_be(q_be)
    );

    // Lane enables: upper half unused on the narrow port.
    always_comb lane_en = cfg_port32 ? q_be : {{(LANES-HALF){1'b0}}, q_be[HALF-1:0]};

    // Pin drive: open rows plus the active bank hold their row strobe low.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            ras_n[b] = !(open_vec[b] || (drv_bank && q_bank == BANK_W'(b)));
        cas_n = cas_act ? ~lane_en : '1;
        we_n  = !we_low;
    end

    // R9: during the grant all strobes are idle and no request is taken.
    a_r9_gnt_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (&ras_n && &cas_n && !req_ready));

    // R7: a column strobe is only given with some row strobe active.
    a_r7_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != '1) |-> (ras_n != '1));

    // R7: upper lanes stay idle on the narrow port.
    a_r7_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_port32 |-> (&cas_n[LANES-1:HALF]));

    // R3: the column was already on the bus the clock before a strobe falls.
    a_r3_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n != '1) && $past(cas_n) == '1) |-> $stable(dram_addr));

    // R3: the row was already on the bus the clock before its strobe falls.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_row_setup
        a_r3_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ras_n[g]) |-> $stable(dram_addr));
    end
endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [26:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [3:0]  req_be = 4'hF;
    logic        cfg_port32 = 1'b1;
    logic [7:0]  cfg_page_en = '0;
    logic [23:0] cfg_bank_size = '0;
    logic        ref_req = 1'b0;
    logic        ref_gnt;
    logic [7:0]  ras_n;
    logic [3:0]  cas_n;
    logic [11:0] dram_addr;
    logic        we_n;
    logic        beat_ack;

    int checks = 0;
    int fails  = 0;
    bit mopen [8];
    int mrow  [8];

    logic [7:0]  s_ras  [0:20];
    logic [3:0]  s_cas  [0:20];
    logic [11:0] s_addr [0:20];
    logic        s_we   [0:20];
    logic        s_ack  [0:20];

    dram_page_ctrl dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int span_bits(input int bank);
        return 17 + int'(cfg_bank_size[bank*3 +: 3]);
    endfunction

    function automatic int col_bits(input int bank);
        int sh = cfg_port32 ? 2 : 1;
        return (span_bits(bank) - sh + 1) / 2;
    endfunction

    // Build an address from bank, row and column under the current config.
    function automatic logic [26:0] mk(input int bank, input int row, input int col);
        int sh = cfg_port32 ? 2 : 1;
        longint off = ((longint'(row) << col_bits(bank)) | longint'(col)) << sh;
        return {3'(bank), 24'(off)};
    endfunction

    // Expected row and column from the address (R2 arithmetic).
    task automatic split(input logic [26:0] a, output int bank, output int row, output int col);
        int sh = cfg_port32 ? 2 : 1;
        longint off, word;
        bank = int'(a[26:24]);
        off  = longint'(a[23:0]) & ((64'd1 << span_bits(bank)) - 1);
        word = off >> sh;
        col  = int'(word & ((64'd1 << col_bits(bank)) - 1));
        row  = int'(word >> col_bits(bank));
    endtask

    task automatic run(input logic [26:0] a, input bit wr, input bit bu, input logic [3:0] be);
        int bank, row, col, kind, b, L, nb;
        bit others_ok;
        logic [3:0] ecas;
        string ktag;
        split(a, bank, row, col);
        kind = !mopen[bank] ? 0 : (mrow[bank] == row ? 1 : 2);
        b    = kind == 1 ? 0 : (kind == 0 ? 2 : 4);
        nb   = bu ? 4 : 1;
        L    = b + 3 + (bu ? 6 : 0) + 1;
        ktag = kind == 2 ? "R5" : "R3";
        ecas = cfg_port32 ? ~be : {2'b11, ~be[1:0]};
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before access", req_ready, 1);
        req_addr = a; req_write = wr; req_burst = bu; req_be = be; req_valid = 1'b1;
        for (int c = 1; c <= L; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            s_ras[c] = ras_n; s_cas[c] = cas_n; s_addr[c] = dram_addr;
            s_we[c] = we_n; s_ack[c] = beat_ack;
        end
        if (kind == 2)
            chk(s_ras[1][bank] && s_ras[2][bank], "R5", "precharge ras high", s_ras[2][bank], 1);
        if (kind != 1) begin
            chk(s_addr[b-1] == 12'(row) && s_addr[b] == 12'(row), "R2", "row addr", s_addr[b], row);
            chk(s_ras[b-1][bank] && !s_ras[b][bank], ktag, "ras fall after row clock",
                {s_ras[b-1][bank], s_ras[b][bank]}, 2'b10);
        end else begin
            chk(!s_ras[1][bank], "R4", "hit keeps ras low", s_ras[1][bank], 0);
        end
        for (int k = 0; k < nb; k++) begin
            int cs = b + 1 + (k == 0 ? 0 : 3 + 2 * (k - 1));
            int len = k == 0 ? 3 : 2;
            int ck = (col & ~3) | ((col + k) & 3);
            chk(s_addr[cs] == 12'(ck), k == 0 ? "R2" : "R8", "column addr", s_addr[cs], ck);
            chk(s_cas[cs] == 4'hF && !s_ras[cs][bank], "R3", "column setup clock", s_cas[cs], 4'hF);
            chk(s_we[cs] == !wr && s_we[cs+1] == !wr, "R10", "we_n in column", s_we[cs], !wr);
            for (int c = cs + 1; c < cs + len; c++) begin
                chk(s_cas[c] == ecas && s_addr[c] == 12'(ck), "R7", "lane strobes", s_cas[c], ecas);
                chk(s_ack[c] == (c == cs + len - 1), "R8", "beat ack cadence", s_ack[c], c == cs + len - 1);
            end
        end
        chk(s_ras[L][bank] == !cfg_page_en[bank], "R6", "ras after access", s_ras[L][bank], !cfg_page_en[bank]);
        chk(s_cas[L] == 4'hF && !s_ack[L] && s_we[L], "R10", "idle after access", s_cas[L], 4'hF);
        others_ok = 1'b1;
        for (int c = 1; c <= L; c++)
            for (int j = 0; j < 8; j++)
                if (j != bank && s_ras[c][j] != !mopen[j]) others_ok = 1'b0;
        chk(others_ok, "R1", "other banks ras unchanged", 0, 1);
        mopen[bank] = cfg_page_en[bank];
        mrow[bank]  = row;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ras_n == 8'hFF && cas_n == 4'hF && we_n && !beat_ack && !ref_gnt,
            "R11", "reset pins", {ras_n, cas_n}, 12'hFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

        // R2 sweep: all sizes, both ports, page mode off (all normal accesses).
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                cfg_port32 = p[0];
                cfg_bank_size = {8{3'(s)}};
                run({3'(s), 24'h5A5A5 ^ 24'(s * 24'h01F3C7)}, 1'b0, 1'b0, 4'hF);
                run({3'(7 - s), ~(24'h5A5A5 ^ 24'(s * 24'h01F3C7))}, 1'b1, 1'b0, 4'h6);
            end
        end

        // Page mode on all banks except bank 2, 32-bit port, size code 2.
        cfg_port32 = 1'b1; cfg_bank_size = {8{3'd2}}; cfg_page_en = 8'hFB;
        run(mk(3, 37, 100), 1'b0, 1'b0, 4'hF);          // R3 normal
        run(mk(3, 37, 200), 1'b0, 1'b0, 4'hF);          // R4 hit
        run(mk(3, 37, 5), 1'b1, 1'b0, 4'b0101);         // R4 hit write, R7 lanes
        run(mk(3, 90, 5), 1'b0, 1'b0, 4'hF);            // R5 miss
        run(mk(5, 12, 7), 1'b0, 1'b0, 4'hF);            // R1 bank 3 stays open
        run(mk(3, 90, 9) | 27'h0800000, 1'b0, 1'b0, 4'hF); // R2 alias bit, hit
        run(mk(6, 4, 10), 1'b0, 1'b1, 4'hF);            // R8 normal burst, wrap
        run(mk(6, 4, 31), 1'b1, 1'b1, 4'hF);            // R8 hit burst write
        run(mk(2, 8, 3), 1'b0, 1'b0, 4'hF);             // R6 disabled bank
        run(mk(2, 8, 4), 1'b0, 1'b0, 4'hF);             // R6 still normal

        // R9: refresh and request together, refresh wins.
        @(negedge clk);
        chk(ras_n[3] == 1'b0 && ras_n[6] == 1'b0, "R9", "pages open before refresh", ras_n, 8'h00);
        ref_req = 1'b1; req_valid = 1'b1; req_addr = mk(3, 90, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ref_gnt && !req_ready && ras_n == 8'hFF && cas_n == 4'hF, "R9", "grant state",
                {ref_gnt, ras_n}, 9'h1FF);
        end
        req_valid = 1'b0; ref_req = 1'b0;
        @(negedge clk);
        chk(!ref_gnt && req_ready, "R9", "grant released", ref_gnt, 0);
        for (int j = 0; j < 8; j++) mopen[j] = 1'b0;
        run(mk(3, 90, 1), 1'b0, 1'b0, 4'hF);            // R9 normal after refresh

        // R7 narrow port: upper enables ignored. Close pages first.
        @(negedge clk); ref_req = 1'b1;
        @(negedge clk); ref_req = 1'b0;
        @(negedge clk);
        for (int j = 0; j < 8; j++) mopen[j] = 1'b0;
        cfg_port32 = 1'b0;
        run(mk(4, 21, 66), 1'b1, 1'b0, 4'b1010);
        run(mk(4, 21, 67), 1'b0, 1'b1, 4'b1101);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule